// File: doc/BRIEF.md
# Banked Scratchpad Data Memory with Bit Access

This block is the on-chip 256-byte working memory of a small 8-bit processor core. The core issues one request per cycle, and the request carries an access mode. The byte mode uses an absolute address. The pointer mode uses a byte held in a working register. The register mode uses a working-register number. The single-bit mode uses a bit number. A two-bit bank field is taken from bits 4:3 of a status byte that the core writes. It decides which group of eight working registers the register mode and the pointer mode use.

The bottom 32 bytes hold the four register groups. Bit numbers below 128 land in the 16 bytes starting at 0x20, and a bit write there is done as a read-modify-write inside the block. An absolute-address access at or above 0x80 is not a memory access at all: it is handed to an external special-register port. A pointer access reaches the full 256 bytes, including the upper half. Bit numbers at or above 0x80 also go to the special-register port. Pointer accesses and bit writes take two cycles, and the block signals this with `busy`.

Top module: `banked_iram`

## Requirements
- R1: After reset, `bank_sel` is 0, `busy` is low and `rd_valid` is low.
- R2: When `psw_we` is high, bits 4:3 of `psw_wdata` become `bank_sel` from the next cycle on. Other bits of the status byte have no effect. A register access in the same cycle still uses the old bank.
- R3: With mode 2 (register), working register n (`req_addr[2:0]`) is the byte at `bank_sel*8 + n`. It is written at the clock edge, and a read returns that byte one cycle later.
- R4: With mode 0 (byte) and an address below 0x80, the byte at that address is written, or is returned one cycle after the request.
- R5: With mode 0 and an address at or above 0x80, `sfr_req` is high in the same cycle, with `sfr_addr`, `sfr_we` and `sfr_wdata` equal to the request, and no memory byte changes. A read returns `sfr_rdata` one cycle later.
- R6: With mode 1 (pointer), the pointer is the byte in register 0 or register 1 of the active bank, chosen by `req_addr[0]`. The access reaches any of the 256 bytes. `busy` is high for the one following cycle, and read data appears two cycles after the request.
- R7: With mode 3 (bit) and a bit number b below 0x80, the bit is bit b[2:0] of byte 0x20 + b[6:3]. A read returns that bit in `rd_data[0]`, with the upper bits zero, one cycle later.
- R8: A bit write below 0x80 keeps `busy` high for one cycle. It changes only the addressed bit, which is set to `req_wdata[0]`.
- R9: With mode 3 and a bit number at or above 0x80, `sfr_req` and `sfr_bit` are high, `sfr_addr` is the bit number unchanged and `sfr_wdata` is `req_wdata[0]` zero-extended. No memory byte changes. A read returns `sfr_rdata[0]` one cycle later.
- R10: A request presented while `busy` is high is ignored: no memory change, no special-register strobe and no read response.
- R11: `rd_valid` is high exactly in the cycle that carries read data, and never as a result of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psw_we | input | 1 | Status byte write strobe |
| psw_wdata | input | 8 | Status byte; bits 4:3 give the bank |
| req_valid | input | 1 | Request present |
| req_mode | input | 2 | 0 byte, 1 pointer, 2 register, 3 bit |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Address, register number, pointer select or bit number |
| req_wdata | input | 8 | Write data (bit writes use bit 0) |
| busy | output | 1 | Second cycle of a two-cycle access |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 8 | Read data |
| bank_sel | output | 2 | Active register bank |
| sfr_req | output | 1 | Special-register access strobe |
| sfr_we | output | 1 | Special-register write |
| sfr_bit | output | 1 | Special-register access is a single bit |
| sfr_addr | output | 8 | Special-register address or bit number |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, valid the cycle after the strobe |

## Verification
The memory is filled with a position-dependent pattern, so a wrong byte index shows up as a wrong value rather than a lucky match. The same byte is then reached in several modes, and a stray upper-bit or bank error gives a different value. Two cases separate the byte mode from the pointer mode in the upper half: the same address is tried in both modes, and a pointer read after a special-register write must still see the memory value. Bit accesses probe the first, last and a middle position of the bit window, and they clear and set bits in a byte that also holds other bits. Back-to-back bit writes to the same byte expose a stale read-modify-write. Requests placed right after a two-cycle operation show whether the ignored cycle leaks a write or a response.

// File: rtl/banked_iram_pkg.sv
package banked_iram_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE    = 2'd0,
      ACC_POINTER = 2'd1,
      ACC_REG     = 2'd2,
      ACC_BIT     = 2'd3
   } acc_mode_e;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_POINTER = 2'd1,
      PH_BITWR   = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      SRC_RAM_BYTE = 2'd0,
      SRC_RAM_BIT  = 2'd1,
      SRC_SFR_BYTE = 2'd2,
      SRC_SFR_BIT  = 2'd3
   } rsp_src_e;

endpackage

// File: rtl/iram_bank_reg.sv
module iram_bank_reg #(
   parameter int DATA_W   = 8,
   parameter int BANK_W   = 2,
   parameter int BANK_LSB = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] status_in,
   output logic [BANK_W-1:0] bank
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         bank <= '0;
      else if (load)
         bank <= status_in[BANK_LSB +: BANK_W];
   end
endmodule

// File: rtl/iram_decode.sv
module iram_decode
   import banked_iram_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BANK_W    = 2,
   parameter int REG_IDX_W = 3,
   parameter int POS_W     = 3,
   parameter int BIT_BASE  = 32,
   parameter int BIT_SPAN  = 128,
   parameter int SFR_BASE  = 128
) (
   input  acc_mode_e         mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   output logic              to_sfr,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [POS_W-1:0]  bit_pos
);
   logic [ADDR_W-1:0] bank_base;
   assign bank_base = ADDR_W'(bank) << REG_IDX_W;

   always_comb begin
      to_sfr   = 1'b0;
      ram_addr = addr;
      bit_pos  = '0;
      unique case (mode)
         ACC_BYTE:    to_sfr = int'(addr) >= SFR_BASE;
         ACC_POINTER: ram_addr = bank_base | ADDR_W'(addr[0]);
         ACC_REG:     ram_addr = bank_base | ADDR_W'(addr[REG_IDX_W-1:0]);
         ACC_BIT: begin
            if (int'(addr) < BIT_SPAN) begin
               ram_addr = ADDR_W'(BIT_BASE) + (addr >> POS_W);
               bit_pos  = addr[POS_W-1:0];
            end else begin
               to_sfr = 1'b1;
            end
         end
         default: to_sfr = 1'b0;
      endcase
   end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 2 ** ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
   parameter int DATA_W = 8,
   parameter int POS_W  = 3
) (
   input  logic [DATA_W-1:0] old_byte,
   input  logic [POS_W-1:0]  pos,
   input  logic              value,
   output logic [DATA_W-1:0] new_byte
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      assign new_byte[i] = (pos == POS_W'(i)) ? value : old_byte[i];
   end
endmodule

// File: rtl/banked_iram.sv
module banked_iram
   import banked_iram_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 8,
   parameter int NUM_BANKS     = 4,
   parameter int REGS_PER_BANK = 8,
   parameter int BIT_BASE      = 32,
   parameter int BIT_BYTES     = 16,
   parameter int SFR_BASE      = 128,
   parameter int BANK_LSB      = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         psw_we,
   input  logic [DATA_W-1:0]            psw_wdata,
   input  logic                         req_valid,
   input  logic [1:0]                   req_mode,
   input  logic                         req_we,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [DATA_W-1:0]            req_wdata,
   output logic                         busy,
   output logic                         rd_valid,
   output logic [DATA_W-1:0]            rd_data,
   output logic [$clog2(NUM_BANKS)-1:0] bank_sel,
   output logic                         sfr_req,
   output logic                         sfr_we,
   output logic                         sfr_bit,
   output logic [ADDR_W-1:0]            sfr_addr,
   output logic [DATA_W-1:0]            sfr_wdata,
   input  logic [DATA_W-1:0]            sfr_rdata
);
   localparam int BANK_W    = $clog2(NUM_BANKS);
   localparam int REG_IDX_W = $clog2(REGS_PER_BANK);
   localparam int POS_W     = $clog2(DATA_W);
   localparam int DEPTH     = 2 ** ADDR_W;
   localparam int BIT_SPAN  = BIT_BYTES * DATA_W;

   if (2 ** POS_W != DATA_W) begin : g_bad_width
      $error("data width must be a power of two");
   end
   if (BANK_LSB + BANK_W > DATA_W) begin : g_bad_lsb
      $error("bank field does not fit the status byte");
   end
   if (NUM_BANKS * REGS_PER_BANK > BIT_BASE) begin : g_bad_banks
      $error("register banks overlap the bit window");
   end
   if (BIT_BASE + BIT_BYTES > SFR_BASE || SFR_BASE >= DEPTH) begin : g_bad_map
      $error("bit window or special-register boundary out of range");
   end
   if (BIT_SPAN >= DEPTH || DATA_W < ADDR_W) begin : g_bad_span
      $error("bit span or pointer width mismatch");
   end

   acc_mode_e         mode;
   phase_e            phase_q, phase_d;
   logic              accept, to_sfr;
   logic [ADDR_W-1:0] dec_addr;
   logic [POS_W-1:0]  dec_pos;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata, ram_rdata, merged;
   logic [ADDR_W-1:0] hold_addr_q;
   logic [POS_W-1:0]  hold_pos_q, rsp_pos_q;
   logic              hold_we_q, rd_valid_q;
   logic [DATA_W-1:0] hold_wdata_q;
   rsp_src_e          rsp_src_q;

   assign mode   = acc_mode_e'(req_mode);
   assign busy   = (phase_q != PH_IDLE);
   assign accept = req_valid && !busy;

   iram_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(psw_we), .status_in(psw_wdata), .bank(bank_sel)
   );

   iram_decode #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_IDX_W(REG_IDX_W), .POS_W(POS_W),
      .BIT_BASE(BIT_BASE), .BIT_SPAN(BIT_SPAN), .SFR_BASE(SFR_BASE)
   ) u_dec (
      .mode(mode), .addr(req_addr), .bank(bank_sel),
      .to_sfr(to_sfr), .ram_addr(dec_addr), .bit_pos(dec_pos)
   );

   iram_bit_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
      .old_byte(ram_rdata), .pos(hold_pos_q), .value(hold_wdata_q[0]), .new_byte(merged)
   );

   iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
   );

   // single storage port: the second phase owns it, otherwise the new request
   always_comb begin
      ram_addr  = dec_addr;
      ram_wdata = req_wdata;
      ram_we    = 1'b0;
      unique case (phase_q)
         PH_POINTER: begin
            ram_addr  = ADDR_W'(ram_rdata);
            ram_wdata = hold_wdata_q;
            ram_we    = hold_we_q;
         end
         PH_BITWR: begin
            ram_addr  = hold_addr_q;
            ram_wdata = merged;
            ram_we    = 1'b1;
         end
         default:
            ram_we = accept && req_we && !to_sfr && (mode == ACC_BYTE || mode == ACC_REG);
      endcase
   end

   always_comb begin
      phase_d = PH_IDLE;
      if (accept) begin
         if (mode == ACC_POINTER)
            phase_d = PH_POINTER;
         else if (mode == ACC_BIT && req_we && !to_sfr)
            phase_d = PH_BITWR;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         rd_valid_q <= 1'b0;
      end else begin
         phase_q    <= phase_d;
         rd_valid_q <= (accept && !req_we && mode != ACC_POINTER) ||
                       (phase_q == PH_POINTER && !hold_we_q);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         hold_addr_q  <= dec_addr;
         hold_pos_q   <= dec_pos;
         hold_we_q    <= req_we;
         hold_wdata_q <= req_wdata;
         rsp_pos_q    <= dec_pos;
         if (to_sfr)
            rsp_src_q <= (mode == ACC_BIT) ? SRC_SFR_BIT : SRC_SFR_BYTE;
         else
            rsp_src_q <= (mode == ACC_BIT) ? SRC_RAM_BIT : SRC_RAM_BYTE;
      end else if (phase_q == PH_POINTER) begin
         rsp_src_q <= SRC_RAM_BYTE;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_valid_q) begin
         unique case (rsp_src_q)
            SRC_RAM_BYTE: rd_data = ram_rdata;
            SRC_RAM_BIT:  rd_data = DATA_W'(ram_rdata[rsp_pos_q]);
            SRC_SFR_BYTE: rd_data = sfr_rdata;
            SRC_SFR_BIT:  rd_data = DATA_W'(sfr_rdata[0]);
            default:      rd_data = '0;
         endcase
      end
   end

   assign rd_valid  = rd_valid_q;
   assign sfr_req   = accept && to_sfr;
   assign sfr_we    = req_we;
   assign sfr_bit   = (mode == ACC_BIT);
   assign sfr_addr  = req_addr;
   assign sfr_wdata = (mode == ACC_BIT) ? DATA_W'(req_wdata[0]) : req_wdata;
endmodule

// File: rtl/iram_chk.sv
module iram_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int BANK_W    = 2,
   parameter int BANK_LSB  = 3,
   parameter int BIT_SPAN  = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psw_we,
   input logic [DATA_W-1:0] psw_wdata,
   input logic              req_valid,
   input logic [1:0]        req_mode,
   input logic              req_we,
   input logic [ADDR_W-1:0] req_addr,
   input logic              busy,
   input logic              rd_valid,
   input logic [BANK_W-1:0] bank_sel,
   input logic              sfr_req,
   input logic              sfr_bit,
   input logic [ADDR_W-1:0] sfr_addr,
   input logic              ram_we
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (bank_sel == '0 && !busy));

   // R2
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_we |=> bank_sel == $past(psw_wdata[BANK_LSB +: BANK_W]));

   // R4
   byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mode == 2'd0 && !req_we) |=> rd_valid);

   // R5
   sfr_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_req |-> !ram_we);

   // R6
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   // R8
   bitwr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mode == 2'd3 && req_we && int'(req_addr) < BIT_SPAN) |=> busy);

   // R9
   sfr_bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_req && sfr_bit) |-> int'(sfr_addr) >= BIT_SPAN);

   // R10
   busy_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sfr_req);

   // R11
   write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_we) |=> !rd_valid);
endmodule

bind banked_iram iram_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB), .BIT_SPAN(BIT_SPAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .psw_we(psw_we), .psw_wdata(psw_wdata),
   .req_valid(req_valid), .req_mode(req_mode), .req_we(req_we), .req_addr(req_addr),
   .busy(busy), .rd_valid(rd_valid), .bank_sel(bank_sel), .sfr_req(sfr_req),
   .sfr_bit(sfr_bit), .sfr_addr(sfr_addr), .ram_we(ram_we)
);

// File: tb/banked_iram_test.sv
module banked_iram_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       psw_we = 1'b0;
   logic [7:0] psw_wdata = '0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = '0;
   logic       req_we = 1'b0;
   logic [7:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       busy, rd_valid, sfr_req, sfr_we, sfr_bit;
   logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;
   logic [1:0] bank_sel;

   always #(CLK_PERIOD / 2) clk = ~clk;

   banked_iram uut (
      .clk(clk), .rst_n(rst_n), .psw_we(psw_we), .psw_wdata(psw_wdata),
      .req_valid(req_valid), .req_mode(req_mode), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .bank_sel(bank_sel),
      .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_bit(sfr_bit),
      .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
   );

   int    errors = 0;
   int    checks = 0;
   bit    started = 1'b0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   // special-register side of the environment
   logic [7:0] sfr_file [256];
   logic [7:0] sfr_rd_q = '0;
   assign sfr_rdata = sfr_rd_q;

   always @(posedge clk) begin
      if (sfr_req) begin
         if (sfr_we) sfr_file[sfr_addr] <= sfr_wdata;
         else        sfr_rd_q <= sfr_file[sfr_addr];
      end
   end

   // behavioural reference model, -1 marks an unknown byte
   int    mem_m [256];
   int    bank_m = 0;
   int    pend_kind = 0;   // 0 none, 1 pointer second cycle, 2 bit write second cycle
   int    pend_a, pend_pos, pend_we, pend_wd;
   string pend_tag;
   bit    exp_rv = 1'b0;
   int    exp_rd = 0;
   string exp_tag = "R11";
   int    m_a, m_ptr, m_byte;

   task automatic expect_read(int v, string tag);
      exp_rv  = 1'b1;
      exp_rd  = v;
      exp_tag = tag;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         bank_m = 0; pend_kind = 0; exp_rv = 1'b0;
      end else begin
         exp_rv = 1'b0;
         if (pend_kind == 1) begin
            m_ptr = mem_m[pend_a];
            if (m_ptr >= 0) begin
               if (pend_we != 0) mem_m[m_ptr] = pend_wd;
               else expect_read(mem_m[m_ptr], pend_tag);
            end else if (pend_we == 0) begin
               expect_read(-1, pend_tag);
            end
            pend_kind = 0;
         end else if (pend_kind == 2) begin
            if (mem_m[pend_a] >= 0)
               mem_m[pend_a] = (pend_wd != 0) ? (mem_m[pend_a] | (1 << pend_pos))
                                              : (mem_m[pend_a] & ~(1 << pend_pos));
            pend_kind = 0;
         end else if (req_valid) begin
            m_a = int'(req_addr);
            case (req_mode)
               2'd0: begin
                  if (m_a < 128) begin
                     if (req_we) mem_m[m_a] = int'(req_wdata);
                     else expect_read(mem_m[m_a], cur_tag);
                  end else if (!req_we) begin
                     expect_read(int'(sfr_file[m_a]), cur_tag);
                  end
               end
               2'd1: begin
                  pend_kind = 1; pend_a = bank_m * 8 + (m_a & 1);
                  pend_we = int'(req_we); pend_wd = int'(req_wdata); pend_tag = cur_tag;
               end
               2'd2: begin
                  m_byte = bank_m * 8 + (m_a & 7);
                  if (req_we) mem_m[m_byte] = int'(req_wdata);
                  else expect_read(mem_m[m_byte], cur_tag);
               end
               default: begin
                  if (m_a < 128) begin
                     m_byte = 32 + (m_a >> 3);
                     if (req_we) begin
                        pend_kind = 2; pend_a = m_byte; pend_pos = m_a & 7;
                        pend_wd = int'(req_wdata) & 1;
                     end else begin
                        expect_read((mem_m[m_byte] < 0) ? -1 : ((mem_m[m_byte] >> (m_a & 7)) & 1), cur_tag);
                     end
                  end else if (!req_we) begin
                     expect_read(int'(sfr_file[m_a]) & 1, cur_tag);
                  end
               end
            endcase
         end
         if (psw_we) bank_m = (int'(psw_wdata) >> 3) & 3;
      end
   end

   task automatic check(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
      end
   endtask

   // compare on every clock, half a period after the edge
   always @(negedge clk) begin
      bit exp_busy, exp_sreq;
      if (rst_n && started && !done) begin
         exp_busy = (pend_kind != 0);
         check(rd_valid == exp_rv, "R11", "rd_valid", int'(rd_valid), int'(exp_rv));
         if (exp_rv && exp_rd >= 0)
            check(int'(rd_data) == exp_rd, exp_tag, "rd_data", int'(rd_data), exp_rd);
         check(busy == exp_busy, "R10", "busy", int'(busy), int'(exp_busy));
         check(int'(bank_sel) == bank_m, "R2", "bank_sel", int'(bank_sel), bank_m);
         exp_sreq = req_valid && !exp_busy && (req_mode == 2'd0 || req_mode == 2'd3) && req_addr >= 8'h80;
         check(sfr_req == exp_sreq, "R5", "sfr_req", int'(sfr_req), int'(exp_sreq));
         if (exp_sreq) begin
            check(sfr_addr == req_addr, "R5", "sfr_addr", int'(sfr_addr), int'(req_addr));
            check(sfr_we == req_we, "R5", "sfr_we", int'(sfr_we), int'(req_we));
            check(sfr_bit == (req_mode == 2'd3), "R9", "sfr_bit", int'(sfr_bit), int'(req_mode == 2'd3));
            check(sfr_wdata == ((req_mode == 2'd3) ? {7'd0, req_wdata[0]} : req_wdata), "R9",
                  "sfr_wdata", int'(sfr_wdata), int'((req_mode == 2'd3) ? {7'd0, req_wdata[0]} : req_wdata));
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic op(int mode, bit we, int addr, int wd);
      req_valid = 1'b1; req_mode = 2'(mode); req_we = we;
      req_addr = 8'(addr); req_wdata = 8'(wd);
      tick();
      req_valid = 1'b0;
      psw_we = 1'b0;
   endtask

   task automatic set_status(int value);
      psw_we = 1'b1; psw_wdata = 8'(value);
      tick();
      psw_we = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_m[i] = -1;
         sfr_file[i] = 8'(i) ^ 8'hA5;
      end
      repeat (3) tick();
      @(negedge clk);
      // R1 reset state
      check(bank_sel == 2'd0, "R1", "bank_sel", int'(bank_sel), 0);
      check(!busy, "R1", "busy", int'(busy), 0);
      check(!rd_valid, "R1", "rd_valid", int'(rd_valid), 0);
      tick();
      rst_n = 1'b1;
      started = 1'b1;
      tick();

      cur_tag = "R4";
      for (int i = 0; i < 128; i++) op(0, 1'b1, i, (i * 37 + 5) & 255);
      op(0, 1'b0, 8'h00, 0); op(0, 1'b0, 8'h1F, 0); op(0, 1'b0, 8'h20, 0);
      op(0, 1'b0, 8'h55, 0); op(0, 1'b0, 8'h7F, 0); tick();

      cur_tag = "R6";
      for (int k = 0; k < 8; k++) begin
         op(0, 1'b1, 8'h00, 8'h80 + k * 16 + 3);
         op(1, 1'b1, 0, 8'hA0 + k);
         tick();
      end
      op(0, 1'b1, 8'h00, 8'h93); op(1, 1'b0, 0, 0); tick(); tick();
      set_status(8'h10);
      op(2, 1'b1, 1, 8'hF3); op(1, 1'b0, 1, 0); tick(); tick();
      op(2, 1'b1, 0, 8'h44); op(1, 1'b1, 0, 8'h3C); tick();
      op(0, 1'b0, 8'h44, 0); tick();

      cur_tag = "R5";
      op(0, 1'b1, 8'h93, 8'h11); op(0, 1'b0, 8'h93, 0); op(0, 1'b0, 8'hF0, 0);
      set_status(8'h00);
      op(1, 1'b0, 0, 0); tick(); tick();

      cur_tag = "R3";
      set_status(8'h18);
      op(2, 1'b1, 5, 8'hC3); op(0, 1'b0, 8'h1D, 0);
      set_status(8'h08);
      op(2, 1'b0, 5, 0); op(2, 1'b1, 2, 8'h6B); op(0, 1'b0, 8'h0A, 0);
      cur_tag = "R2";
      set_status(8'hE7);
      op(2, 1'b0, 7, 0);
      psw_we = 1'b1; psw_wdata = 8'h10;
      op(2, 1'b1, 6, 8'h5E);
      op(0, 1'b0, 8'h06, 0); op(2, 1'b0, 6, 0); tick();

      cur_tag = "R7";
      op(3, 1'b0, 8'h00, 0); op(3, 1'b0, 8'h07, 0); op(3, 1'b0, 8'h7F, 0);
      op(3, 1'b0, 8'h13, 0); op(3, 1'b0, 8'h40, 0); tick();

      cur_tag = "R8";
      op(3, 1'b1, 8'h13, 8'h00); tick();
      op(3, 1'b1, 8'h7F, 8'h01); tick();
      op(3, 1'b1, 8'h00, 8'hFE); tick();
      op(0, 1'b0, 8'h22, 0); op(0, 1'b0, 8'h2F, 0); op(0, 1'b0, 8'h20, 0);
      op(3, 1'b0, 8'h13, 0);
      op(3, 1'b1, 8'h10, 8'h01); op(3, 1'b1, 8'h11, 8'h01);
      op(3, 1'b1, 8'h16, 8'h01); tick();
      op(0, 1'b0, 8'h22, 0); tick();

      cur_tag = "R9";
      op(3, 1'b1, 8'h85, 8'hFF); op(3, 1'b0, 8'h85, 0); op(3, 1'b0, 8'hC2, 0);
      op(3, 1'b1, 8'h85, 8'hFE); op(3, 1'b0, 8'h85, 0); tick();

      cur_tag = "R10";
      set_status(8'h00);
      op(1, 1'b1, 0, 8'h77); op(0, 1'b1, 8'h30, 8'hEE); tick();
      op(0, 1'b0, 8'h30, 0);
      op(3, 1'b1, 8'h01, 8'h01); op(0, 1'b0, 8'h90, 0);
      op(1, 1'b0, 0, 0); op(0, 1'b0, 8'h30, 0); tick();
      op(0, 1'b0, 8'h20, 0); tick();

      cur_tag = "R11";
      op(2, 1'b1, 3, 8'h29); op(2, 1'b0, 3, 0); tick(); tick();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule